// File: doc/BRIEF.md
# CAN Time-Stamp Capture and Insertion Unit

This block keeps a 16-bit free-running time base for the time-triggered mode of a CAN controller. The counter moves one step per nominal bit time. When the bit engine signals the sample point of a start-of-frame bit, the block copies the counter into a stamp register. There is one stamp register for transmitted frames and one for received frames, and each is presented as a high byte and a low byte.

For an outgoing frame that asks for global time, the block rewrites the data field as it streams past. The two last payload bytes are replaced by the stamp captured at that frame's own start of frame: byte 6 carries the low byte and byte 7 carries the high byte. The bit engine supplies payload bytes with their index and takes back the possibly modified byte one clock later. The caller sets the frame direction, the global-time request and the data length code for the whole frame.

Top module: `can_tstamp_unit`

## Requirements
- R1: While `tt_en` is low the time counter is held at zero, so a capture in the first enabled cycle after a disabled stretch stores 0 no matter how many ticks arrived while disabled.
- R2: While `tt_en` is high the counter increments by one on each cycle in which `bit_tick` is high, and it wraps from 0xFFFF to 0x0000.
- R3: When `sof_strobe` and `tt_en` are both high, the counter value of that cycle (before any increment in the same cycle) is loaded into the transmit stamp if `frame_is_tx` is 1, or into the receive stamp if it is 0. The new stamp is visible on the outputs after the next rising clock edge.
- R4: A capture into one direction's stamp leaves the other direction's stamp unchanged.
- R5: A `sof_strobe` while `tt_en` is low changes neither stamp.
- R6: `out_valid` equals `pay_valid` delayed by one clock, and `out_byte` is produced in that same delayed cycle.
- R7: When `tt_en`, `gtime_en` and `frame_is_tx` are all 1 and `dlc` is 8, the payload byte at `pay_idx` 6 leaves as the transmit stamp's low byte and the one at index 7 as its high byte; indexes 0 to 5 pass unchanged.
- R8: If `dlc` is not 8, or any of `tt_en`, `gtime_en` or `frame_is_tx` is 0, every payload byte passes unchanged.
- R9: After reset both stamps, the counter and `out_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tt_en | input | 1 | Time-triggered mode enable |
| bit_tick | input | 1 | One pulse per nominal bit time |
| sof_strobe | input | 1 | Sample point of the start-of-frame bit |
| frame_is_tx | input | 1 | 1 for an outgoing frame, 0 for an incoming one |
| gtime_en | input | 1 | Outgoing frame requests global-time insertion |
| dlc | input | 4 | Data length code of the current frame |
| pay_valid | input | 1 | Payload byte present |
| pay_idx | input | 3 | Index of the payload byte in the data field |
| pay_byte | input | 8 | Payload byte from the bit engine |
| out_valid | output | 1 | Outgoing payload byte present |
| out_byte | output | 8 | Payload byte, possibly replaced by the stamp |
| tx_stamp_hi | output | 8 | Transmit stamp, high byte |
| tx_stamp_lo | output | 8 | Transmit stamp, low byte |
| rx_stamp_hi | output | 8 | Receive stamp, high byte |
| rx_stamp_lo | output | 8 | Receive stamp, low byte |

## Verification
The bench runs the counter through a full 65,536-step wrap and captures on both sides of it. A counter that saturated or skipped zero would store the wrong value at that point. Disabled stretches full of ticks are followed by an immediate capture, which exposes a counter that only pauses instead of clearing. Byte substitution is driven with a stamp whose two bytes differ, so swapped halves show up, and then with each of the four blocking conditions, so a gate that ignored the length, the direction or the mode would corrupt the bytes it should pass. A capture on a strobe coincident with a tick checks that the stamp takes the value from before the increment.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } frame_dir_e;

   localparam int N_DIR = 2;

endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   if (CNT_W < 2) begin : g_bad_w
      $error("tstamp_counter: CNT_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count <= '0;
      else if (!run)    count <= '0;
      else if (tick)    count <= count + 1'b1;
   end

   // idle clears the time base
   assert_zero_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> count == '0);

   // one step per tick, natural wrap
   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick) |=> count == CNT_W'($past(count) + 1'b1));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(count));

endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] stamp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stamp <= '0;
      else if (load) stamp <= cnt_in;
   end

   assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> stamp == $past(cnt_in));

   // no load keeps the stamp steady for the frame's data field
   assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(stamp));

endmodule

// File: rtl/tstamp_inserter.sv
module tstamp_inserter #(
   parameter int BYTE_W    = 8,
   parameter int DLC_W     = 4,
   parameter int STAMP_DLC = 8,
   parameter int IDX_W     = 3,
   parameter bit PIPE_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_en,
   input  logic [DLC_W-1:0]  dlc,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic [BYTE_W-1:0] stamp_lo,
   input  logic [BYTE_W-1:0] stamp_hi,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte
);

   localparam logic [IDX_W-1:0] LO_IDX   = IDX_W'(STAMP_DLC - 2);
   localparam logic [IDX_W-1:0] HI_IDX   = IDX_W'(STAMP_DLC - 1);
   localparam logic [DLC_W-1:0] FULL_DLC = DLC_W'(STAMP_DLC);

   if (STAMP_DLC < 2 || STAMP_DLC > (1 << IDX_W)) begin : g_bad_len
      $error("tstamp_inserter: STAMP_DLC out of range for IDX_W");
   end

   logic              full_frame;
   logic              take_lo;
   logic              take_hi;
   logic [BYTE_W-1:0] mux_byte;

   always_comb begin
      full_frame = (dlc == FULL_DLC);
      take_lo    = ins_en && full_frame && (in_idx == LO_IDX);
      take_hi    = ins_en && full_frame && (in_idx == HI_IDX);
      if (take_lo)      mux_byte = stamp_lo;
      else if (take_hi) mux_byte = stamp_hi;
      else              mux_byte = in_byte;
   end

   if (PIPE_OUT) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
         end else begin
            out_valid <= in_valid;
            out_byte  <= mux_byte;
         end
      end

      assert_valid_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !ins_en) |=> out_byte == $past(in_byte));
      assert_short_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dlc != FULL_DLC) |=> out_byte == $past(in_byte));
      assert_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && ins_en && dlc == FULL_DLC && in_idx == LO_IDX)
         |=> out_byte == $past(stamp_lo));
   end else begin : g_comb
      always_comb begin
         out_valid = in_valid;
         out_byte  = mux_byte;
      end
   end

endmodule

// File: rtl/can_tstamp_unit.sv
module can_tstamp_unit
   import tstamp_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int CNT_W     = 16,
   parameter int DLC_W     = 4,
   parameter int STAMP_DLC = 8,
   parameter bit PIPE_OUT  = 1'b1,
   localparam int IDX_W    = (STAMP_DLC > 1) ? $clog2(STAMP_DLC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tt_en,
   input  logic              bit_tick,
   input  logic              sof_strobe,
   input  logic              frame_is_tx,
   input  logic              gtime_en,
   input  logic [DLC_W-1:0]  dlc,
   input  logic              pay_valid,
   input  logic [IDX_W-1:0]  pay_idx,
   input  logic [BYTE_W-1:0] pay_byte,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_byte,
   output logic [BYTE_W-1:0] tx_stamp_hi,
   output logic [BYTE_W-1:0] tx_stamp_lo,
   output logic [BYTE_W-1:0] rx_stamp_hi,
   output logic [BYTE_W-1:0] rx_stamp_lo
);

   if (CNT_W != 2 * BYTE_W) begin : g_bad_split
      $error("can_tstamp_unit: stamp must split into two bytes");
   end

   logic [CNT_W-1:0] time_cnt;
   logic [CNT_W-1:0] stamp_q [N_DIR];
   logic [N_DIR-1:0] load_dir;
   logic             ins_en;

   tstamp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tt_en),
      .tick  (bit_tick),
      .count (time_cnt)
   );

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      assign load_dir[d] = tt_en && sof_strobe && (frame_is_tx == d[0]);
      tstamp_capture #(.CNT_W(CNT_W)) u_cap (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load_dir[d]),
         .cnt_in (time_cnt),
         .stamp  (stamp_q[d])
      );
   end

   assign tx_stamp_hi = stamp_q[DIR_TX][CNT_W-1:BYTE_W];
   assign tx_stamp_lo = stamp_q[DIR_TX][BYTE_W-1:0];
   assign rx_stamp_hi = stamp_q[DIR_RX][CNT_W-1:BYTE_W];
   assign rx_stamp_lo = stamp_q[DIR_RX][BYTE_W-1:0];

   assign ins_en = tt_en && gtime_en && frame_is_tx;

   tstamp_inserter #(
      .BYTE_W    (BYTE_W),
      .DLC_W     (DLC_W),
      .STAMP_DLC (STAMP_DLC),
      .IDX_W     (IDX_W),
      .PIPE_OUT  (PIPE_OUT)
   ) u_ins (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_en    (ins_en),
      .dlc       (dlc),
      .in_valid  (pay_valid),
      .in_idx    (pay_idx),
      .in_byte   (pay_byte),
      .stamp_lo  (stamp_q[DIR_TX][BYTE_W-1:0]),
      .stamp_hi  (stamp_q[DIR_TX][CNT_W-1:BYTE_W]),
      .out_valid (out_valid),
      .out_byte  (out_byte)
   );

   // a capture on one side never disturbs the other
   assert_other_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sof_strobe && frame_is_tx) |=> $stable(stamp_q[DIR_RX]));

   // no capture while the mode is off
   assert_no_cap_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tt_en |=> ($stable(stamp_q[DIR_TX]) && $stable(stamp_q[DIR_RX])));

endmodule

// File: tb/can_tstamp_unit_bench.sv
`timescale 1ns/1ps
module can_tstamp_unit_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tt_en = 1'b0, bit_tick = 1'b0, sof_strobe = 1'b0;
   logic       frame_is_tx = 1'b0, gtime_en = 1'b0;
   logic [3:0] dlc = 4'd0;
   logic       pay_valid = 1'b0;
   logic [2:0] pay_idx = 3'd0;
   logic [7:0] pay_byte = 8'd0;
   logic       out_valid;
   logic [7:0] out_byte, tx_stamp_hi, tx_stamp_lo, rx_stamp_hi, rx_stamp_lo;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [15:0] m_cnt = '0, m_tx = '0, m_rx = '0;
   logic        m_ov = 1'b0;
   logic [7:0]  m_ob = '0;

   always #4 clk = ~clk;

   can_tstamp_unit u_can_tstamp_unit (
      .clk(clk), .rst_n(rst_n), .tt_en(tt_en), .bit_tick(bit_tick),
      .sof_strobe(sof_strobe), .frame_is_tx(frame_is_tx), .gtime_en(gtime_en),
      .dlc(dlc), .pay_valid(pay_valid), .pay_idx(pay_idx), .pay_byte(pay_byte),
      .out_valid(out_valid), .out_byte(out_byte),
      .tx_stamp_hi(tx_stamp_hi), .tx_stamp_lo(tx_stamp_lo),
      .rx_stamp_hi(rx_stamp_hi), .rx_stamp_lo(rx_stamp_lo)
   );

   function automatic logic [7:0] exp_byte(logic tt, logic gt, logic tx,
                                           logic [3:0] l, logic [2:0] i,
                                           logic [7:0] b, logic [15:0] st);
      if (tt && gt && tx && l == 4'd8 && i == 3'd6) return st[7:0];
      if (tt && gt && tx && l == 4'd8 && i == 3'd7) return st[15:8];
      return b;
   endfunction

   task automatic cmp(string tag, logic [15:0] act, logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      cmp({tag, " R3 tx stamp"}, {tx_stamp_hi, tx_stamp_lo}, m_tx);
      cmp({tag, " R3 rx stamp"}, {rx_stamp_hi, rx_stamp_lo}, m_rx);
      cmp({tag, " R6 out_valid"}, {15'd0, out_valid}, {15'd0, m_ov});
      if (m_ov) cmp({tag, " R7 out_byte"}, {8'd0, out_byte}, {8'd0, m_ob});
   endtask

   // one clock: model follows the pre-edge inputs, outputs sampled at negedge
   task automatic step(bit chk, string tag);
      @(posedge clk);
      m_ov = pay_valid;
      m_ob = exp_byte(tt_en, gtime_en, frame_is_tx, dlc, pay_idx, pay_byte, m_tx);
      if (tt_en && sof_strobe) begin
         if (frame_is_tx) m_tx = m_cnt;
         else             m_rx = m_cnt;
      end
      if (!tt_en)        m_cnt = '0;
      else if (bit_tick) m_cnt = m_cnt + 16'd1;
      @(negedge clk);
      if (chk) check_all(tag);
   endtask

   task automatic idle_inputs();
      bit_tick = 0; sof_strobe = 0; pay_valid = 0;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      check_all("R9 reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R1 ticks while disabled, then capture in first enabled cycle
      tt_en = 0; bit_tick = 1;
      repeat (20) step(1'b0, "");
      tt_en = 1; bit_tick = 1; sof_strobe = 1; frame_is_tx = 1;
      step(1'b1, "R1");
      cmp("R1 capture after disable", {tx_stamp_hi, tx_stamp_lo}, 16'h0000);
      idle_inputs();

      // R2 full wrap
      tt_en = 0; step(1'b0, "");
      tt_en = 1; bit_tick = 1;
      repeat (65535) step(1'b0, "");
      bit_tick = 0; sof_strobe = 1; frame_is_tx = 0;
      step(1'b1, "R2");
      cmp("R2 top value", {rx_stamp_hi, rx_stamp_lo}, 16'hFFFF);
      sof_strobe = 0; bit_tick = 1;
      step(1'b1, "R2");
      // R3 strobe coincident with tick: value before increment
      sof_strobe = 1; frame_is_tx = 1; bit_tick = 1;
      step(1'b1, "R3");
      cmp("R2 wrap to zero", {tx_stamp_hi, tx_stamp_lo}, 16'h0000);
      cmp("R4 rx untouched", {rx_stamp_hi, rx_stamp_lo}, 16'hFFFF);
      idle_inputs();

      // R5 strobe while disabled
      tt_en = 0; sof_strobe = 1; frame_is_tx = 1;
      step(1'b1, "R5");
      frame_is_tx = 0; step(1'b1, "R5");
      cmp("R5 tx held", {tx_stamp_hi, tx_stamp_lo}, 16'h0000);
      cmp("R5 rx held", {rx_stamp_hi, rx_stamp_lo}, 16'hFFFF);
      idle_inputs();

      // R7 stamp 0x1234 into a full frame
      tt_en = 1; bit_tick = 1;
      repeat (16'h1234) step(1'b0, "");
      bit_tick = 0; sof_strobe = 1; frame_is_tx = 1;
      step(1'b1, "R3");
      cmp("R3 tx stamp 1234", {tx_stamp_hi, tx_stamp_lo}, 16'h1234);
      sof_strobe = 0; gtime_en = 1; dlc = 4'd8; bit_tick = 1;
      for (int i = 0; i < 8; i++) begin
         pay_valid = 1; pay_idx = 3'(i); pay_byte = 8'hA0 + 8'(i);
         step(1'b1, "R7");
         cmp("R7 frame byte", {8'd0, out_byte},
             {8'd0, (i == 6) ? 8'h34 : (i == 7) ? 8'h12 : 8'hA0 + 8'(i)});
      end

      // R8 each blocking condition
      for (int c = 0; c < 4; c++) begin
         tt_en = (c != 3); gtime_en = (c != 1); frame_is_tx = (c != 2);
         dlc = (c == 0) ? 4'd7 : 4'd8;
         for (int i = 6; i < 8; i++) begin
            pay_valid = 1; pay_idx = 3'(i); pay_byte = 8'h5A ^ 8'(c * 16 + i);
            step(1'b1, "R8");
            cmp("R8 passthrough", {8'd0, out_byte}, {8'd0, 8'h5A ^ 8'(c * 16 + i)});
         end
      end
      pay_valid = 0;
      step(1'b1, "R6");
      cmp("R6 valid drops", {15'd0, out_valid}, 16'd0);

      // random mix
      for (int k = 0; k < 4000; k++) begin
         tt_en       = ($urandom % 8) != 0;
         bit_tick    = $urandom % 2;
         sof_strobe  = ($urandom % 6) == 0;
         frame_is_tx = $urandom % 2;
         gtime_en    = $urandom % 2;
         dlc         = ($urandom % 2) ? 4'd8 : 4'($urandom % 16);
         pay_valid   = $urandom % 2;
         pay_idx     = 3'($urandom);
         pay_byte    = 8'($urandom);
         step(1'b1, "R3/R7 random");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule